// File: doc/BRIEF.md
# Counted Block Disk Write Port

This peripheral sits at a single memory-mapped address and turns a stream of CPU writes into writes of whole disk blocks. It has two phases. While it waits for a block number, a CPU write is stored as the index of the block to overwrite. After that, the port collects data. Each CPU write becomes one write to a synchronous storage interface. That interface carries the block index, the word offset within the block, the data word and a write enable. The block holds 128 words (512 bytes), so once its last word has been committed the port waits for a block number again.

The CPU can read the port but always gets zero. A status output shows which phase the port is in, so software and the bench can see where the sequence stands. Writes may arrive on every cycle without stalls. Each accepted data write appears on the storage interface on the next clock edge.

Top module: `sector_store_port`

## Requirements
- R1: After reset, `idle_o` is 1 and `st_we` is 0, and the word counter is cleared.
- R2: A CPU write made while `idle_o` is 1 is taken as the block number. It produces no storage write, and `idle_o` is 0 from the following cycle.
- R3: Each CPU write made while `idle_o` is 0 produces exactly one `st_we` pulse, one cycle later. That pulse carries the written data on `st_data` and the latched block number on `st_block`.
- R4: Within one block the storage offsets on `st_offset` run 0, 1, 2 and so on up to 127, in the order the data writes arrive.
- R5: After the 128th data write `idle_o` returns to 1 and the counter returns to 0. The next CPU write is taken as a new block number.
- R6: `cpu_rdata` is zero in every phase. A read does not change the phase or the word position.
- R7: CPU writes on consecutive cycles are all accepted, and each one yields its own storage write.
- R8: `idle_o` is 1 exactly while a block number is awaited and 0 while data words are being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe for the port address |
| cpu_rd | input | 1 | CPU read strobe for the port address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data, always zero |
| idle_o | output | 1 | 1 while waiting for a block number |
| st_we | output | 1 | Storage write enable |
| st_block | output | BLK_W | Storage block index |
| st_offset | output | OFS_W | Storage word offset within the block |
| st_data | output | DATA_W | Storage write data |

## Verification
Some properties are checked by assertions on every cycle:
- A block-number write leaves the waiting phase.
- Every data write is followed by exactly one enable pulse carrying its data and offset.
- The counter steps by one, and wraps back to the waiting phase at the last word.
- A read leaves the phase and the counter unchanged, and the read data is zero.

Other behaviour can only be shown by the bench scenarios:
- The full sequence of 128 offsets and data for a block.
- Correct block numbers across successive blocks.
- Gapped versus back-to-back streams.
- Resuming the counter correctly after reads in the middle of a block.

// File: rtl/sstp_pkg.sv
package sstp_pkg;
   typedef enum logic {
      PH_BLOCK = 1'b0,
      PH_DATA  = 1'b1
   } phase_t;
endpackage

// File: rtl/sstp_seq.sv
module sstp_seq
   import sstp_pkg::*;
#(
   parameter int WORDS = 128,
   parameter int OFS_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   output logic             idle_o,
   output logic             load_blk_o,
   output logic             take_o,
   output logic [OFS_W-1:0] ofs_o
);
   localparam logic [OFS_W-1:0] LAST = OFS_W'(WORDS - 1);

   phase_t           phase_q;
   logic [OFS_W-1:0] ofs_q;
   logic             at_last;

   assign at_last    = (ofs_q == LAST);
   assign load_blk_o = wr_i && (phase_q == PH_BLOCK);
   assign take_o     = wr_i && (phase_q == PH_DATA);
   assign idle_o     = (phase_q == PH_BLOCK);
   assign ofs_o      = ofs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_BLOCK;
         ofs_q   <= '0;
      end else if (load_blk_o) begin
         phase_q <= PH_DATA;
         ofs_q   <= '0;
      end else if (take_o) begin
         if (at_last) begin
            phase_q <= PH_BLOCK;
            ofs_q   <= '0;
         end else begin
            ofs_q   <= ofs_q + 1'b1;
         end
      end
   end

   // R2: block number write moves to the data phase
   a_r2_leave_idle: assert property (@(posedge clk) disable iff (!rst_n)
      load_blk_o |=> (!idle_o && ofs_o == '0));
   // R4: counter advances by one per data word below the last
   a_r4_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && ofs_o != LAST) |=> (!idle_o && ofs_o == $past(ofs_o) + 1'b1));
   // R5: the last word returns the port to waiting
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && ofs_o == LAST) |=> (idle_o && ofs_o == '0));
   // R8: no write means no phase change
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> ($stable(idle_o) && $stable(ofs_o)));
endmodule

// File: rtl/sstp_commit.sv
module sstp_commit #(
   parameter int DATA_W  = 32,
   parameter int BLK_W   = 32,
   parameter int OFS_W   = 7,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_blk_i,
   input  logic              take_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              we_o,
   output logic [BLK_W-1:0]  blk_o,
   output logic [OFS_W-1:0]  ofs_o,
   output logic [DATA_W-1:0] data_o
);
   logic [BLK_W-1:0] blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          blk_q <= '0;
      else if (load_blk_i) blk_q <= BLK_W'(wdata_i);
   end

   assign blk_o = blk_q;

   generate
      if (REG_OUT) begin : g_reg
         logic              we_q;
         logic [OFS_W-1:0]  ofs_q;
         logic [DATA_W-1:0] data_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               we_q   <= 1'b0;
               ofs_q  <= '0;
               data_q <= '0;
            end else begin
               we_q <= take_i;
               if (take_i) begin
                  ofs_q  <= ofs_i;
                  data_q <= wdata_i;
               end
            end
         end

         assign we_o   = we_q;
         assign ofs_o  = ofs_q;
         assign data_o = data_q;

         // R3: one pulse per data write, carrying that word
         a_r3_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            take_i |=> (we_o && data_o == $past(wdata_i) && ofs_o == $past(ofs_i)));
         a_r3_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
            !take_i |=> !we_o);
      end else begin : g_comb
         assign we_o   = take_i;
         assign ofs_o  = ofs_i;
         assign data_o = wdata_i;
      end
   endgenerate
endmodule

// File: rtl/sector_store_port.sv
module sector_store_port #(
   parameter int DATA_W  = 32,
   parameter int BLK_W   = 32,
   parameter int WORDS   = 128,
   parameter bit REG_OUT = 1'b1,
   localparam int OFS_W  = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              idle_o,
   output logic              st_we,
   output logic [BLK_W-1:0]  st_block,
   output logic [OFS_W-1:0]  st_offset,
   output logic [DATA_W-1:0] st_data
);
   generate
      if (WORDS < 2 || (1 << OFS_W) != WORDS) begin : g_bad_words
         $error("WORDS must be a power of two of at least 2");
      end
      if (DATA_W < 1 || BLK_W < 1) begin : g_bad_width
         $error("DATA_W and BLK_W must be positive");
      end
   endgenerate

   logic             load_blk;
   logic             take;
   logic [OFS_W-1:0] ofs;

   sstp_seq #(.WORDS(WORDS), .OFS_W(OFS_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (cpu_wr),
      .idle_o    (idle_o),
      .load_blk_o(load_blk),
      .take_o    (take),
      .ofs_o     (ofs)
   );

   sstp_commit #(.DATA_W(DATA_W), .BLK_W(BLK_W), .OFS_W(OFS_W), .REG_OUT(REG_OUT)) u_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_blk_i(load_blk),
      .take_i    (take),
      .ofs_i     (ofs),
      .wdata_i   (cpu_wdata),
      .we_o      (st_we),
      .blk_o     (st_block),
      .ofs_o     (st_offset),
      .data_o    (st_data)
   );

   assign cpu_rdata = '0;

   // R6: reads return zero and leave the phase untouched
   a_r6_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |-> (cpu_rdata == '0));
   a_r6_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !cpu_wr) |=> ($stable(idle_o) && $stable(ofs)));
   // R1: nothing is written before the first data word
   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && !$past(take)) |-> !st_we);
endmodule

// File: tb/sector_store_port_test.sv
`timescale 1ns/1ps
module sector_store_port_test;
   localparam int DW = 32;
   localparam int BW = 32;
   localparam int NW = 128;
   localparam int OW = $clog2(NW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_wr = 1'b0;
   logic          cpu_rd = 1'b0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          idle_o;
   logic          st_we;
   logic [BW-1:0] st_block;
   logic [OW-1:0] st_offset;
   logic [DW-1:0] st_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [BW-1:0] log_blk [0:255];
   logic [OW-1:0] log_ofs [0:255];
   logic [DW-1:0] log_dat [0:255];
   int log_n = 0;

   always #2.5 clk = ~clk;

   sector_store_port uut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .idle_o(idle_o),
      .st_we(st_we), .st_block(st_block), .st_offset(st_offset), .st_data(st_data)
   );

   always @(negedge clk) begin
      if (rst_n && st_we && log_n < 256) begin
         log_blk[log_n] = st_block;
         log_ofs[log_n] = st_offset;
         log_dat[log_n] = st_data;
         log_n = log_n + 1;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [DW-1:0] v, input int gap);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_wdata = v;
      @(negedge clk);
      cpu_wr = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
   endtask

   // R1
   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 idle after reset", idle_o, 1);
      check("R1 no write after reset", st_we, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 still idle", idle_o, 1);
   endtask

   // R2 R3 R4 R5 R7 R8: full block; gap=0 gives back-to-back writes
   task automatic t_fill(input logic [BW-1:0] blk, input int gap);
      int bad = 0;
      log_n = 0;
      cpu_write(DW'(blk), gap);
      check("R2 no storage write for block number", log_n, 0);
      check("R8 collecting after block number", idle_o, 0);
      @(negedge clk);
      cpu_wr = 1'b0;
      for (int i = 0; i < NW; i++) begin
         cpu_wr = 1'b1; cpu_wdata = blk * 1000 + i;
         @(negedge clk);
         if (gap != 0) begin
            cpu_wr = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
         end
         if (i < NW - 1) check("R8 collecting mid block", idle_o, 0);
      end
      cpu_wr = 1'b0;
      @(negedge clk);
      check(gap == 0 ? "R7 all back-to-back writes accepted" : "R3 write count", log_n, NW);
      for (int i = 0; i < NW && i < log_n; i++) begin
         if (log_ofs[i] !== OW'(i) || log_dat[i] !== DW'(blk * 1000 + i) || log_blk[i] !== blk)
            bad++;
      end
      check("R4 offsets ascend with data and block", bad, 0);
      check("R3 first word block", log_blk[0], blk);
      check("R5 idle after last word", idle_o, 1);
   endtask

   // R6: reads return zero and do not move the counter
   task automatic t_reads(input logic [BW-1:0] blk);
      log_n = 0;
      cpu_write(DW'(blk), 0);
      cpu_write(32'hAAAA0000, 0);
      cpu_write(32'hAAAA0001, 0);
      @(negedge clk);
      cpu_rd = 1'b1;
      check("R6 read zero in data phase", cpu_rdata, 0);
      repeat (4) @(negedge clk);
      check("R6 read zero after reads", cpu_rdata, 0);
      cpu_rd = 1'b0;
      check("R6 reads make no storage write", log_n, 2);
      check("R6 phase unchanged by reads", idle_o, 0);
      cpu_write(32'hAAAA0002, 1);
      check("R6 counter resumes after reads", log_ofs[2], 2);
      check("R3 data after reads", log_dat[2], 32'hAAAA0002);
      check("R2 new block number used", log_blk[2], blk);
      for (int i = 3; i < NW; i++) cpu_write(DW'(i), 0);
      check("R5 idle after finishing block", idle_o, 1);
      cpu_rd = 1'b1;
      @(negedge clk);
      check("R6 read zero while idle", cpu_rdata, 0);
      cpu_rd = 1'b0;
      check("R6 read leaves idle", idle_o, 1);
   endtask

   initial begin
      t_reset();
      t_fill(32'h15, 0);
      t_fill(32'h2A, 1);
      t_reads(32'h77);
      t_fill(32'h3, 0);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule